// File: doc/BRIEF.md
# Power domain switch sequencer

This block brings one switchable logic domain up or down through a fixed series of steps. A power-up starts with two staged power-switch enables and waits for both switch status inputs. It then lifts the clock gate, removes isolation, releases the domain reset and powers the SRAM arrays back up. A power-down runs the same steps mirrored. The block drives a five-bit control word whose bit positions a neighbouring switch cell decodes. It also drives the SRAM power-down lines, and optionally a bus-protection request, which it engages before power-down and releases after power-up.

A request is a one-cycle pulse on the on or off input. The block reports progress with busy, a one-cycle done pulse, a sticky error flag and the current on/off status. Every wait for an external acknowledge has its own timeout of `TMO_CYC` cycles. When a wait times out, the sequence stops with all outputs frozen. Parameters choose the SRAM power-down width and the acknowledge width, whether the SRAM acknowledge wait is used, and whether the bus-protection step is used.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, `pwr_ctl` is 5'b10010 (bit 0 active-low domain reset = 0, bit 1 isolation = 1, bit 2 primary enable = 0, bit 3 secondary enable = 0, bit 4 clock disable = 1). All `sram_pdn` bits are 1, `bprot_req` equals HAS_BPROT, and busy, done, err and pwr_on are 0.
- R2: A power-up changes exactly one output item per step, in this order: bit 2 set, bit 3 set, bit 4 cleared, bit 1 cleared, bit 0 set, all `sram_pdn` cleared, then `bprot_req` cleared (when HAS_BPROT). It then ends with done, pwr_on = 1 and `pwr_ctl` = 5'b01101.
- R3: After both enables are set, the clock-disable bit is not cleared until `sw_ack1` and `sw_ack2` are both high. One acknowledge alone does not advance the sequence.
- R4: After clearing `sram_pdn`, power-up waits until every `sram_ack` bit is 0 before it continues. With USE_ACK = 0 this wait is skipped and `sram_ack` is ignored.
- R5: A power-down follows this order, one item per step: `bprot_req` set, then a wait for `bprot_ack` high (when HAS_BPROT). Next, all `sram_pdn` set and a wait until every `sram_ack` bit is 1 (when USE_ACK). Then bit 1 set, bit 0 cleared, bit 4 set, bit 2 cleared, bit 3 cleared, and a wait for both switch acknowledges low. It ends with done and pwr_on = 0.
- R6: With HAS_BPROT = 0, `bprot_req` stays 0 at all times, and both sequences complete without any bus-protection step.
- R7: If a wait sees no acknowledge for TMO_CYC consecutive cycles, err is set and busy drops, and all control outputs hold their values. An acknowledge present in the last of those cycles still lets the sequence proceed without error.
- R8: err stays set until the next on or off request. That request clears err and starts the full requested sequence.
- R9: An on request while on, or an off request while off, gives done in the next cycle with busy low and no change on any control output.
- R10: Requests that arrive while busy have no effect on the running sequence or on the final state.
- R11: busy is high from the cycle after an accepted request until the sequence ends. done is high for exactly one cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| sw_ack1 | input | 1 | Primary power switch status |
| sw_ack2 | input | 1 | Secondary power switch status |
| sram_ack | input | ACK_W | SRAM power-down acknowledges |
| bprot_ack | input | 1 | Bus-protection acknowledge |
| pwr_ctl | output | 5 | Control word: bit 0 reset_n, 1 isolation, 2 primary enable, 3 secondary enable, 4 clock disable |
| sram_pdn | output | PDN_W | SRAM power-down lines |
| bprot_req | output | 1 | Bus-protection request (1 = engaged) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout error |
| pwr_on | output | 1 | Domain is fully on |

## Verification
The delicate coincidence is a switch acknowledge that arrives in exactly the last cycle of a wait, the same cycle in which the timeout would expire. The bench holds both switch acknowledges low and counts cycles from the edge that sets the secondary enable. It raises the acknowledges just before the final sampled edge and requires err to stay low, with the clock-disable bit clearing one cycle later. A companion run leaves them low and requires err to appear after exactly TMO_CYC cycles with the outputs frozen.

// File: rtl/pwr_domain_seq.sv
`timescale 1ns/1ps
module pwr_domain_seq #(
  parameter int PDN_W     = 4,
  parameter int ACK_W     = 4,
  parameter bit USE_ACK   = 1'b1,
  parameter bit HAS_BPROT = 1'b1,
  parameter int TMO_CYC   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_on,
  input  logic             req_off,
  input  logic             sw_ack1,
  input  logic             sw_ack2,
  input  logic [ACK_W-1:0] sram_ack,
  input  logic             bprot_ack,
  output logic [4:0]       pwr_ctl,
  output logic [PDN_W-1:0] sram_pdn,
  output logic             bprot_req,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             pwr_on
);
  localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [TW-1:0] TOP = TW'(TMO_CYC - 1);
  localparam int B_RSTN = 0, B_ISO = 1, B_EN1 = 2, B_EN2 = 3, B_CKD = 4;

  typedef enum logic [4:0] {
    S_IDLE, S_ERR,
    U_EN1, U_EN2, U_WPWR, U_CLK, U_ISO, U_RST, U_SRAM, U_WSRAM, U_BPR, U_WBP, U_FIN,
    D_BPR, D_WBP, D_SRAM, D_WSRAM, D_ISO, D_RST, D_CLK, D_EN1, D_EN2, D_WPWR, D_FIN
  } st_t;

  st_t st;
  logic [TW-1:0] tmr;

  assign busy = (st != S_IDLE) && (st != S_ERR);

  st_t first_dn, after_usram;
  assign first_dn    = HAS_BPROT ? D_BPR : D_SRAM;
  assign after_usram = USE_ACK ? U_WSRAM : (HAS_BPROT ? U_BPR : U_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pwr_ctl   <= 5'b10010;
      sram_pdn  <= '1;
      bprot_req <= HAS_BPROT;
      pwr_on    <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      tmr       <= TOP;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_on) begin
            if (pwr_on) done <= 1'b1;
            else        st   <= U_EN1;
          end else if (req_off) begin
            if (!pwr_on) done <= 1'b1;
            else         st   <= first_dn;
          end
        end
        S_ERR: begin
          if (req_on) begin
            err <= 1'b0;
            st  <= U_EN1;
          end else if (req_off) begin
            err <= 1'b0;
            st  <= first_dn;
          end
        end
        U_EN1: begin pwr_ctl[B_EN1] <= 1'b1; st <= U_EN2; end
        U_EN2: begin pwr_ctl[B_EN2] <= 1'b1; tmr <= TOP; st <= U_WPWR; end
        U_WPWR: begin
          if (sw_ack1 && sw_ack2) st <= U_CLK;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        U_CLK: begin pwr_ctl[B_CKD]  <= 1'b0; st <= U_ISO; end
        U_ISO: begin pwr_ctl[B_ISO]  <= 1'b0; st <= U_RST; end
        U_RST: begin pwr_ctl[B_RSTN] <= 1'b1; st <= U_SRAM; end
        U_SRAM: begin sram_pdn <= '0; tmr <= TOP; st <= after_usram; end
        U_WSRAM: begin
          if (sram_ack == '0) st <= HAS_BPROT ? U_BPR : U_FIN;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        U_BPR: begin bprot_req <= 1'b0; tmr <= TOP; st <= U_WBP; end
        U_WBP: begin
          if (!bprot_ack) st <= U_FIN;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        U_FIN: begin pwr_on <= 1'b1; done <= 1'b1; st <= S_IDLE; end
        D_BPR: begin bprot_req <= 1'b1; tmr <= TOP; st <= D_WBP; end
        D_WBP: begin
          if (bprot_ack) st <= D_SRAM;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        D_SRAM: begin sram_pdn <= '1; tmr <= TOP; st <= USE_ACK ? D_WSRAM : D_ISO; end
        D_WSRAM: begin
          if (&sram_ack) st <= D_ISO;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        D_ISO: begin pwr_ctl[B_ISO]  <= 1'b1; st <= D_RST; end
        D_RST: begin pwr_ctl[B_RSTN] <= 1'b0; st <= D_CLK; end
        D_CLK: begin pwr_ctl[B_CKD]  <= 1'b1; st <= D_EN1; end
        D_EN1: begin pwr_ctl[B_EN1]  <= 1'b0; st <= D_EN2; end
        D_EN2: begin pwr_ctl[B_EN2]  <= 1'b0; tmr <= TOP; st <= D_WPWR; end
        D_WPWR: begin
          if (!sw_ack1 && !sw_ack2) st <= D_FIN;
          else if (tmr == '0) begin st <= S_ERR; err <= 1'b1; end
          else tmr <= tmr - 1'b1;
        end
        D_FIN: begin pwr_on <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pwr_domain_seq_chk #(
  parameter int PDN_W     = 4,
  parameter bit HAS_BPROT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_ack1,
  input logic             sw_ack2,
  input logic [4:0]       pwr_ctl,
  input logic [PDN_W-1:0] sram_pdn,
  input logic             bprot_req,
  input logic             busy,
  input logic             done,
  input logic             err
);
  logic [6:0] word;
  assign word = {bprot_req, sram_pdn[0], pwr_ctl};

  assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word ^ $past(word)) <= 1);

  assert_iso_after_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[1]) |-> (!pwr_ctl[4] && pwr_ctl[2] && pwr_ctl[3]));

  assert_rst_after_iso_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ctl[0]) |-> !pwr_ctl[1]);

  assert_clk_after_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[4]) |-> ($past(sw_ack1, 2) && $past(sw_ack2, 2)));

  assert_en_off_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ctl[2]) |-> (pwr_ctl[1] && !pwr_ctl[0] && pwr_ctl[4]));

  assert_frozen_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(err)) |-> ($stable(pwr_ctl) && $stable(sram_pdn) && $stable(bprot_req)));

  assert_err_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && err));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  generate
    if (!HAS_BPROT) begin : g_nobp
      assert_no_bprot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bprot_req);
    end
  endgenerate
endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(.PDN_W(PDN_W), .HAS_BPROT(HAS_BPROT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_ack1(sw_ack1), .sw_ack2(sw_ack2),
  .pwr_ctl(pwr_ctl), .sram_pdn(sram_pdn), .bprot_req(bprot_req),
  .busy(busy), .done(done), .err(err)
);

// File: tb/test_pwr_domain_seq.sv
`timescale 1ns/1ps
module test_pwr_domain_seq;
  localparam int TMO = 16;
  localparam logic [4:0] CTL_OFF = 5'b10010, CTL_ON = 5'b01101, CTL_ERR = 5'b11110;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // DUT A: default-style domain with bus protection and SRAM acks
  logic a_on = 0, a_off = 0, a_auto = 1;
  logic a_m1 = 0, a_m2 = 0, a_mbp = 1;
  logic [3:0] a_msr = 4'hF;
  logic m_a1, m_a2, m_abp;
  logic [3:0] m_asr;
  logic a_ack1, a_ack2, a_bpa;
  logic [3:0] a_sra;
  logic [4:0] a_ctl;
  logic [3:0] a_pdn;
  logic a_bpr, a_busy, a_done, a_err, a_pon;

  always_ff @(posedge clk) begin
    m_a1 <= a_ctl[2]; m_a2 <= a_ctl[3]; m_abp <= a_bpr; m_asr <= {4{&a_pdn}};
  end
  assign a_ack1 = a_auto ? m_a1  : a_m1;
  assign a_ack2 = a_auto ? m_a2  : a_m2;
  assign a_bpa  = a_auto ? m_abp : a_mbp;
  assign a_sra  = a_auto ? m_asr : a_msr;

  pwr_domain_seq #(.PDN_W(4), .ACK_W(4), .USE_ACK(1'b1), .HAS_BPROT(1'b1), .TMO_CYC(TMO)) i_pwr_domain_seq (
    .clk(clk), .rst_n(rst_n), .req_on(a_on), .req_off(a_off),
    .sw_ack1(a_ack1), .sw_ack2(a_ack2), .sram_ack(a_sra), .bprot_ack(a_bpa),
    .pwr_ctl(a_ctl), .sram_pdn(a_pdn), .bprot_req(a_bpr),
    .busy(a_busy), .done(a_done), .err(a_err), .pwr_on(a_pon));

  // DUT B: no bus protection, SRAM ack wait skipped, wider power-down field
  logic b_on = 0, b_off = 0;
  logic m_b1, m_b2;
  logic [4:0] b_ctl;
  logic [5:0] b_pdn;
  logic b_bpr, b_busy, b_done, b_err, b_pon;
  logic b_bp_seen = 0;

  always_ff @(posedge clk) begin
    m_b1 <= b_ctl[2]; m_b2 <= b_ctl[3];
  end

  pwr_domain_seq #(.PDN_W(6), .ACK_W(2), .USE_ACK(1'b0), .HAS_BPROT(1'b0), .TMO_CYC(TMO)) i_pwr_domain_seq_b (
    .clk(clk), .rst_n(rst_n), .req_on(b_on), .req_off(b_off),
    .sw_ack1(m_b1), .sw_ack2(m_b2), .sram_ack(2'b11), .bprot_ack(1'b1),
    .pwr_ctl(b_ctl), .sram_pdn(b_pdn), .bprot_req(b_bpr),
    .busy(b_busy), .done(b_done), .err(b_err), .pwr_on(b_pon));

  // change monitor for DUT A: index 0..4 control bits, 5 SRAM power-down, 6 bus protection
  int lg [0:63];
  int lg_n = 0;
  logic mon_bad = 0;
  logic [6:0] prv;
  always @(negedge clk) begin
    logic [6:0] cur, d;
    cur = {a_bpr, a_pdn[0], a_ctl};
    if (rst_n) begin
      d = cur ^ prv;
      if (d != 0) begin
        if ($countones(d) != 1) mon_bad = 1;
        else for (int i = 0; i < 7; i++) if (d[i]) begin lg[lg_n % 64] = i; lg_n++; end
      end
      if (b_bpr) b_bp_seen = 1;
    end
    prv = cur;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic a_req(input bit on);
    @(negedge clk);
    if (on) a_on = 1; else a_off = 1;
    @(negedge clk);
    a_on = 0; a_off = 0;
  endtask

  task automatic b_req(input bit on);
    @(negedge clk);
    if (on) b_on = 1; else b_off = 1;
    @(negedge clk);
    b_on = 0; b_off = 0;
  endtask

  task automatic a_wait_done(input string req);
    int n = 0;
    while (!a_done && n < 200) begin @(negedge clk); n++; end
    chk(a_done, req, "done seen", a_done, 1);
  endtask

  task automatic chk_order(input int base, input logic [27:0] exp, input string req);
    chk(lg_n - base == 7, req, "step count", lg_n - base, 7);
    for (int k = 0; k < 7; k++)
      chk(lg[(base + k) % 64] == int'(exp[4*(6-k) +: 4]), req, "step item", lg[(base + k) % 64], int'(exp[4*(6-k) +: 4]));
    chk(!mon_bad, req, "one item per step", mon_bad, 0);
  endtask

  task automatic t_reset;
    chk(a_ctl == CTL_OFF, "R1", "ctl", a_ctl, CTL_OFF);
    chk(a_pdn == 4'hF, "R1", "sram_pdn", a_pdn, 15);
    chk(a_bpr == 1, "R1", "bprot_req", a_bpr, 1);
    chk({a_busy, a_done, a_err, a_pon} == 0, "R1", "status", {a_busy, a_done, a_err, a_pon}, 0);
    chk(b_bpr == 0, "R1", "bprot_req no-prot", b_bpr, 0);
  endtask

  task automatic t_power_up;
    int base = lg_n;
    a_req(1);
    chk(a_busy, "R11", "busy after request", a_busy, 1);
    a_wait_done("R2");
    chk(!a_busy, "R11", "busy at done", a_busy, 0);
    chk(a_pon, "R2", "pwr_on", a_pon, 1);
    chk(a_ctl == CTL_ON, "R2", "ctl", a_ctl, CTL_ON);
    chk(a_pdn == 0 && a_bpr == 0, "R2", "pdn/bprot", {a_bpr, a_pdn}, 0);
    chk_order(base, 28'h2341056, "R2");
    @(negedge clk);
    chk(!a_done, "R11", "done one cycle", a_done, 0);
  endtask

  task automatic t_power_down;
    int base = lg_n;
    a_req(0);
    a_wait_done("R5");
    chk(!a_pon, "R5", "pwr_on", a_pon, 0);
    chk(a_ctl == CTL_OFF, "R5", "ctl", a_ctl, CTL_OFF);
    chk(a_pdn == 4'hF && a_bpr, "R5", "pdn/bprot", {a_bpr, a_pdn}, 31);
    chk_order(base, 28'h6510423, "R5");
    @(negedge clk);
  endtask

  task automatic t_redundant(input bit on);
    logic [4:0] c0 = a_ctl;
    a_req(on);
    chk(a_done && !a_busy, "R9", "immediate done", {a_done, a_busy}, 2);
    chk(a_ctl == c0, "R9", "ctl unchanged", a_ctl, c0);
    @(negedge clk);
    chk(!a_done && a_ctl == c0, "R9", "quiet after", a_done, 0);
  endtask

  task automatic t_busy_ignore;
    a_req(1);
    repeat (3) @(negedge clk);
    chk(a_busy, "R10", "busy before extra request", a_busy, 1);
    a_req(0);
    a_req(1);
    a_wait_done("R10");
    chk(a_pon && a_ctl == CTL_ON, "R10", "final on", a_ctl, CTL_ON);
    repeat (3) @(negedge clk);
    chk(!a_busy && a_ctl == CTL_ON, "R10", "no late sequence", a_busy, 0);
    t_power_down();
  endtask

  task automatic t_both_acks;
    a_auto = 0; a_m1 = 0; a_m2 = 0; a_msr = 4'hF; a_mbp = 1;
    a_req(1);
    while (!a_ctl[3]) @(negedge clk);
    a_m1 = 1;
    repeat (5) @(negedge clk);
    chk(a_ctl[4] && a_busy && !a_err, "R3", "held with one ack", a_ctl[4], 1);
    a_m2 = 1;
    repeat (3) @(negedge clk);
    chk(!a_ctl[4], "R3", "clk enabled after both acks", a_ctl[4], 0);
    while (a_pdn != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(a_bpr && a_busy, "R4", "held on SRAM acks", a_bpr, 1);
    a_msr = 4'h0;
    repeat (3) @(negedge clk);
    chk(!a_bpr, "R4", "continues after SRAM acks clear", a_bpr, 0);
    a_mbp = 0;
    a_wait_done("R4");
    a_auto = 1;
    @(negedge clk);
    t_power_down();
  endtask

  task automatic t_timeout;
    a_auto = 0; a_m1 = 0; a_m2 = 0; a_msr = 4'hF; a_mbp = 1;
    a_req(1);
    while (!a_ctl[3]) @(negedge clk);
    for (int k = 1; k < TMO; k++) begin
      @(negedge clk);
      if (a_err) chk(0, "R7", "early err at cycle", k, TMO);
    end
    @(negedge clk);
    chk(a_err && !a_busy, "R7", "err after timeout", a_err, 1);
    chk(a_ctl == CTL_ERR, "R7", "ctl frozen", a_ctl, CTL_ERR);
    repeat (3) @(negedge clk);
    chk(a_err && a_ctl == CTL_ERR && a_pdn == 4'hF, "R8", "err held", a_err, 1);
    a_auto = 1;
    a_req(0);
    chk(!a_err && a_busy, "R8", "request clears err", {a_err, a_busy}, 1);
    a_wait_done("R8");
    chk(!a_pon && a_ctl == CTL_OFF, "R8", "off after restart", a_ctl, CTL_OFF);
    @(negedge clk);
  endtask

  task automatic t_last_cycle_ack;
    a_auto = 0; a_m1 = 0; a_m2 = 0; a_msr = 4'hF; a_mbp = 1;
    a_req(1);
    while (!a_ctl[3]) @(negedge clk);
    repeat (TMO - 1) @(negedge clk);
    a_m1 = 1; a_m2 = 1;
    @(negedge clk);
    chk(!a_err && a_busy, "R7", "ack in last cycle wins", a_err, 0);
    @(negedge clk);
    chk(!a_ctl[4], "R7", "clk enabled after late ack", a_ctl[4], 0);
    a_auto = 1;
    a_wait_done("R7");
    chk(a_pon && !a_err, "R7", "on after late ack", a_pon, 1);
    @(negedge clk);
    t_power_down();
  endtask

  task automatic t_variant;
    int n = 0;
    b_req(1);
    while (!b_done && n < 200) begin @(negedge clk); n++; end
    chk(b_done && b_pon, "R4", "no-ack variant powers up", b_pon, 1);
    chk(b_ctl == CTL_ON && b_pdn == 0, "R4", "variant on state", b_ctl, CTL_ON);
    n = 0;
    b_req(0);
    while (!b_done && n < 200) begin @(negedge clk); n++; end
    chk(b_done && !b_pon, "R6", "variant powers down", b_pon, 0);
    chk(b_ctl == CTL_OFF && b_pdn == 6'h3F, "R6", "variant off state", b_pdn, 63);
    chk(!b_bp_seen && !b_err, "R6", "bprot never requested", b_bp_seen, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_redundant(0);
    t_power_up();
    t_redundant(1);
    t_power_down();
    t_busy_ignore();
    t_both_acks();
    t_timeout();
    t_last_cycle_ack();
    t_variant();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule